// File: doc/BRIEF.md
# Half-Bridge Gate Command Interlock

This block sits between a digital controller and the gate drivers of one half-bridge leg. It takes a high-side command and a low-side command and produces two gate-enable outputs. Both outputs are never high in the same cycle. When the two commands overlap, the command that became active first keeps its output and the other output stays off. A shutdown input forces both gates off. After shutdown is released, the gates stay off until a command input shows a fresh rising edge.

Two undervoltage flags are also inputs. One belongs to the low-side supply and turns off both gates. The other belongs to the floating high-side supply and turns off only the high-side gate. Each flag passes through a persistence filter whose length is set in clock cycles. A flag therefore changes state only after the raw input has held its new level for the full filter length, and short glitches in either direction are ignored. All inputs are assumed to be synchronous to the clock.

Top module: `hb_gate_interlock`

## Requirements
- R1: While reset is high, both gate outputs are low whatever the inputs are. Reset also clears the shutdown latch, the arbitration state and both filter counters.
- R2: When exactly one command is high, its gate output goes high on the clock edge after the command was sampled, and the other gate stays low.
- R3: While both commands are high, only the gate of the command that went high earlier is high.
- R4: When the winning command falls while the other command is still high, the other gate goes high one cycle later.
- R5: If both commands rise on the same edge, the low-side gate wins. gateHi and gateLo are never both high.
- R6: A cycle in which shutdown is sampled high is followed by a cycle in which both gates are low.
- R7: After shutdown is released, both gates stay low, including when a command is held high through the release. They leave this state only when a command input rises (low in one sampled cycle, high in the next).
- R8: The low-side-supply flag turns off both gates once it has been sampled high on FILT_CYC consecutive edges. The gates are low from the edge after that. Release takes the same number of stable low samples.
- R9: A raw flag change that lasts fewer than FILT_CYC consecutive samples, in either direction, has no effect on the gates.
- R10: The filtered high-side-supply flag forces only gateHi low. gateLo still follows a lone low-side command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdHi | input | 1 | High-side command |
| cmdLo | input | 1 | Low-side command |
| shutdown | input | 1 | Forces both gates off and arms the re-enable latch |
| uvLowSupply | input | 1 | Raw undervoltage flag of the low-side supply |
| uvHighSupply | input | 1 | Raw undervoltage flag of the floating high-side supply |
| gateHi | output | 1 | High-side gate enable |
| gateLo | output | 1 | Low-side gate enable |

## Verification
The bench builds the block with FILT_CYC set to 4 instead of the default of about ten microseconds. With this value, both sides of the filter boundary can be reached in a few cycles: a flag held for one sample too few is rejected, and the first cycle in which the gates react can be checked exactly. The same short window is used to reject a glitch on release. Arbitration and shutdown checks do not depend on the parameter and sample the outputs one cycle after each input change.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Which command currently holds the bridge
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_HI   = 2'd1,
    OWN_LO   = 2'd2
  } owner_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic grantHi;
    logic grantLo;
  } gateStrb_t;

  localparam int UV_LOW_IDX  = 0;
  localparam int UV_HIGH_IDX = 1;
  localparam int UV_FLAGS    = 2;

endpackage

// File: rtl/hb_cmd_ctrl.sv
module hb_cmd_ctrl
  import hb_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      cmdHi,
  input  logic      cmdLo,
  input  logic      shutdown,
  output gateStrb_t strb
);

  logic   prevHi, prevLo;
  logic   sdHold;
  owner_e owner, ownerNext;
  logic   riseHi, riseLo, anyRise, blocked;

  assign riseHi  = cmdHi & ~prevHi;
  assign riseLo  = cmdLo & ~prevLo;
  assign anyRise = riseHi | riseLo;

  // Arbitration: a lone command takes ownership. With both high, the
  // current owner keeps it, and a simultaneous arrival goes to low side.
  always_comb begin
    ownerNext = OWN_NONE;
    unique case ({cmdHi, cmdLo})
      2'b10: ownerNext = OWN_HI;
      2'b01: ownerNext = OWN_LO;
      2'b11: ownerNext = (owner == OWN_HI) ? OWN_HI : OWN_LO;
      default: ownerNext = OWN_NONE;
    endcase
  end

  // Gates are blocked during shutdown and after it until a fresh edge
  assign blocked = shutdown | (sdHold & ~anyRise);

  always_comb begin
    strb.grantHi = ~blocked & (ownerNext == OWN_HI);
    strb.grantLo = ~blocked & (ownerNext == OWN_LO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevHi <= 1'b0;
      prevLo <= 1'b0;
      sdHold <= 1'b0;
      owner  <= OWN_NONE;
    end else begin
      prevHi <= cmdHi;
      prevLo <= cmdLo;
      owner  <= ownerNext;
      if (shutdown)      sdHold <= 1'b1;
      else if (anyRise)  sdHold <= 1'b0;
    end
  end

  // R3
  first_hi_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cmdHi && !cmdLo) && cmdHi && cmdLo) |-> !strb.grantLo);

  // R3
  first_lo_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cmdLo && !cmdHi) && cmdHi && cmdLo) |-> !strb.grantHi);

endmodule

// File: rtl/hb_gate_path.sv
module hb_gate_path
  import hb_pkg::*;
#(
  parameter int FILT_CYC = 1250
) (
  input  logic      clk,
  input  logic      rst,
  input  gateStrb_t strb,
  input  logic      uvLow,
  input  logic      uvHigh,
  output logic      gateHi,
  output logic      gateLo
);

  localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [UV_FLAGS-1:0] uvRaw;
  logic [UV_FLAGS-1:0] uvFilt;

  assign uvRaw[UV_LOW_IDX]  = uvLow;
  assign uvRaw[UV_HIGH_IDX] = uvHigh;

  // One persistence filter per flag, symmetric on set and clear
  for (genvar g = 0; g < UV_FLAGS; g++) begin : g_filt
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt       <= '0;
        uvFilt[g] <= 1'b0;
      end else if (uvRaw[g] != uvFilt[g]) begin
        if (cnt == LAST) begin
          cnt       <= '0;
          uvFilt[g] <= uvRaw[g];
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end

    // R9
    filt_follows_raw_chk: assert property (@(posedge clk) disable iff (rst)
      (uvFilt[g] != $past(uvFilt[g])) |-> ($past(uvRaw[g]) == uvFilt[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gateHi <= 1'b0;
      gateLo <= 1'b0;
    end else begin
      gateLo <= strb.grantLo & ~uvFilt[UV_LOW_IDX];
      gateHi <= strb.grantHi & ~uvFilt[UV_LOW_IDX] & ~uvFilt[UV_HIGH_IDX];
    end
  end

  // R5
  no_shoot_through_chk: assert property (@(posedge clk) disable iff (rst)
    !(gateHi && gateLo));

  // R8
  low_uv_kills_both_chk: assert property (@(posedge clk) disable iff (rst)
    uvFilt[UV_LOW_IDX] |=> (!gateHi && !gateLo));

  // R10
  high_uv_kills_hi_chk: assert property (@(posedge clk) disable iff (rst)
    uvFilt[UV_HIGH_IDX] |=> !gateHi);

endmodule

// File: rtl/hb_gate_interlock.sv
module hb_gate_interlock
  import hb_pkg::*;
#(
  parameter int FILT_CYC = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic cmdHi,
  input  logic cmdLo,
  input  logic shutdown,
  input  logic uvLowSupply,
  input  logic uvHighSupply,
  output logic gateHi,
  output logic gateLo
);

  gateStrb_t strb;

  hb_cmd_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmdHi    (cmdHi),
    .cmdLo    (cmdLo),
    .shutdown (shutdown),
    .strb     (strb)
  );

  hb_gate_path #(.FILT_CYC(FILT_CYC)) u_path (
    .clk    (clk),
    .rst    (rst),
    .strb   (strb),
    .uvLow  (uvLowSupply),
    .uvHigh (uvHighSupply),
    .gateHi (gateHi),
    .gateLo (gateLo)
  );

  // R6
  shutdown_off_chk: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> (!gateHi && !gateLo));

endmodule

// File: tb/hb_gate_interlock_tb.sv
`timescale 1ns/1ps
module hb_gate_interlock_tb;

  localparam int FILT = 4;

  logic clk = 1'b0;
  logic rst, cmdHi, cmdLo, shutdown, uvLowSupply, uvHighSupply;
  logic gateHi, gateLo;
  int   total = 0;
  int   bad   = 0;
  logic done  = 1'b0;

  always #4 clk = ~clk;

  hb_gate_interlock #(.FILT_CYC(FILT)) u_dut (
    .clk(clk), .rst(rst), .cmdHi(cmdHi), .cmdLo(cmdLo), .shutdown(shutdown),
    .uvLowSupply(uvLowSupply), .uvHighSupply(uvHighSupply),
    .gateHi(gateHi), .gateLo(gateLo)
  );

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic expHi, input logic expLo);
    total++;
    if (gateHi !== expHi || gateLo !== expLo) begin
      bad++;
      $display("FAIL %s: gateHi/gateLo=%b%b expected %b%b", req, gateHi, gateLo, expHi, expLo);
    end
  endtask

  task automatic testReset();
    rst = 1'b1; cmdHi = 1'b1; cmdLo = 1'b0; shutdown = 1'b0;
    uvLowSupply = 1'b0; uvHighSupply = 1'b0;
    tick(3);
    chk("R1", 1'b0, 1'b0);
    cmdHi = 1'b0; rst = 1'b0;
    tick();
    chk("R1", 1'b0, 1'b0);
  endtask

  task automatic testSingle();
    cmdHi = 1'b1; tick(); chk("R2", 1'b1, 1'b0);
    cmdHi = 1'b0; tick(); chk("R2", 1'b0, 1'b0);
    cmdLo = 1'b1; tick(); chk("R2", 1'b0, 1'b1);
    cmdLo = 1'b0; tick(); chk("R2", 1'b0, 1'b0);
  endtask

  task automatic testOverlap();
    cmdHi = 1'b1; tick();
    cmdLo = 1'b1; tick(); chk("R3", 1'b1, 1'b0);
    tick(); chk("R3", 1'b1, 1'b0);
    cmdHi = 1'b0; tick(); chk("R4", 1'b0, 1'b1);
    cmdHi = 1'b1; tick(); chk("R3", 1'b0, 1'b1);
    cmdLo = 1'b0; tick(); chk("R4", 1'b1, 1'b0);
    cmdHi = 1'b0; tick(); chk("R2", 1'b0, 1'b0);
  endtask

  task automatic testSimultaneous();
    cmdHi = 1'b1; cmdLo = 1'b1; tick(); chk("R5", 1'b0, 1'b1);
    tick(); chk("R5", 1'b0, 1'b1);
    cmdHi = 1'b0; cmdLo = 1'b0; tick(); chk("R5", 1'b0, 1'b0);
  endtask

  task automatic testShutdown();
    cmdHi = 1'b1; tick(); chk("R2", 1'b1, 1'b0);
    shutdown = 1'b1; tick(); chk("R6", 1'b0, 1'b0);
    tick(); chk("R6", 1'b0, 1'b0);
    shutdown = 1'b0; tick(); chk("R7", 1'b0, 1'b0);
    tick(3); chk("R7", 1'b0, 1'b0);
    cmdHi = 1'b0; tick(); chk("R7", 1'b0, 1'b0);
    cmdHi = 1'b1; tick(); chk("R7", 1'b1, 1'b0);
    cmdHi = 1'b0; tick();
  endtask

  task automatic testUvLow();
    cmdLo = 1'b1; tick(); chk("R2", 1'b0, 1'b1);
    uvLowSupply = 1'b1; tick(FILT - 1);
    uvLowSupply = 1'b0; tick(); chk("R9", 1'b0, 1'b1);
    tick(2); chk("R9", 1'b0, 1'b1);
    uvLowSupply = 1'b1; tick(FILT); chk("R8", 1'b0, 1'b1);
    tick(); chk("R8", 1'b0, 1'b0);
    uvLowSupply = 1'b0; tick(FILT - 1);
    uvLowSupply = 1'b1; tick(); chk("R9", 1'b0, 1'b0);
    uvLowSupply = 1'b0; tick(FILT); chk("R8", 1'b0, 1'b0);
    tick(); chk("R8", 1'b0, 1'b1);
    cmdLo = 1'b0; cmdHi = 1'b1; tick(); chk("R2", 1'b1, 1'b0);
    uvLowSupply = 1'b1; tick(FILT + 1); chk("R8", 1'b0, 1'b0);
    uvLowSupply = 1'b0; tick(FILT + 1); chk("R8", 1'b1, 1'b0);
    cmdHi = 1'b0; tick();
  endtask

  task automatic testUvHigh();
    cmdHi = 1'b1; tick(); chk("R2", 1'b1, 1'b0);
    uvHighSupply = 1'b1; tick(FILT + 1); chk("R10", 1'b0, 1'b0);
    cmdHi = 1'b0; cmdLo = 1'b1; tick(); chk("R10", 1'b0, 1'b1);
    cmdLo = 1'b0; uvHighSupply = 1'b0; tick(FILT + 1);
    cmdHi = 1'b1; tick(); chk("R10", 1'b1, 1'b0);
    cmdHi = 1'b0; tick();
  endtask

  initial begin
    testReset();
    testSingle();
    testOverlap();
    testSimultaneous();
    testShutdown();
    testUvLow();
    testUvHigh();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule